// File: doc/BRIEF.md
# Multi-channel DShot frame transmitter

This block drives a set of motor control lines with DShot frames. Every channel has a staging register that takes an 11-bit throttle value and a telemetry request flag. A single commit strobe launches every staged channel in the same clock cycle. All launched channels then run off one shared bit timebase, so their frames stay aligned bit for bit.

For each launched channel the block forms a 16-bit frame that ends in a 4-bit XOR checksum. It sends the frame most significant bit first. Each bit is a fixed slot of 20 ticks, and the time the line spends at its active level tells a one from a zero. A mode input picks the tick rate for the 150, 300 or 600 kbit/s speeds. The tick period comes from the system clock frequency, which is a parameter.

Each channel has a busy flag and an output polarity control. A global enable gates the whole block.

Top module: `pulse_frame_tx`

## Requirements
- R1: The frame is 16 bits: bits 15..5 hold the throttle value, bit 4 holds the telemetry request flag and bits 3..0 hold the checksum.
- R2: The checksum is the XOR of the three nibbles of the 12-bit word {throttle, request}.
- R3: Frame bits go out most significant bit first, 16 bit slots per frame.
- R4: Every bit slot lasts exactly 20 ticks, with the tick count running 0 to 19.
- R5: A one bit is active for the first 14 ticks of its slot and a zero bit for the first 7. The line is inactive for the rest of the slot.
- R6: `mode` selects the tick rate: 2'b00 gives 3 MHz, 2'b01 gives 6 MHz, and 2'b10 or 2'b11 give 12 MHz. One tick lasts CLK_HZ/rate clock cycles, which is a prescale value of CLK_HZ/rate - 1. The rate is captured at commit, and later changes to `mode` do not affect a frame in flight.
- R7: A commit seen at a clock edge starts every staged channel at that edge. Their busy flags rise together and their first slots begin in the cycle that follows. Channels with nothing staged stay idle.
- R8: A launched channel stays busy for exactly 320 ticks. After that it clears its busy flag and holds its line at the inactive level.
- R9: While `enable` is low, writes and commits are ignored, any frame in flight stops at the next edge and every line sits at its inactive level.
- R10: A set `invert` bit makes that channel active-low and idle-high. A clear bit makes it active-high and idle-low.
- R11: A write to a busy channel is ignored. A commit while any frame is in flight is ignored. A staged value is sent once by the next accepted commit and is then no longer staged.
- R12: After reset no channel is busy, nothing is staged and every line is at its inactive level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Global enable |
| mode | input | 2 | Speed select, captured at commit |
| invert | input | NUM_CH | Per-channel output polarity, 1 = active-low |
| wr_en | input | NUM_CH | Per-channel write strobe into the staging register |
| wr_throttle | input | NUM_CH*11 | Throttle values, channel c in bits [c*11 +: 11] |
| wr_telem | input | NUM_CH | Telemetry request flag, one per channel |
| commit | input | 1 | Launch all staged channels |
| busy | output | NUM_CH | Channel is sending a frame |
| line_out | output | NUM_CH | Motor signal lines |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that a launch can only happen while the shared timebase is idle, because that is what lets every busy flag follow a single run flag. The stimulus changes inputs only on the falling edge and holds each strobe for exactly one cycle. It sends writes and commits in the middle of a frame on purpose, to show that they are refused, and it does not rely on the same-cycle order of a write and a commit to one idle channel.

// File: rtl/pft_pkg.sv
package pft_pkg;
  localparam int THR_W      = 11;
  localparam int WORD_W     = THR_W + 1;
  localparam int FRAME_W    = 16;
  localparam int SLOT_TICKS = 20;
  localparam int HIGH_ONE   = 14;
  localparam int HIGH_ZERO  = 7;
  localparam int TICK_W     = $clog2(SLOT_TICKS);
  localparam int BIT_W      = $clog2(FRAME_W);

  localparam int RATE_150_HZ = 3_000_000;
  localparam int RATE_300_HZ = 6_000_000;
  localparam int RATE_600_HZ = 12_000_000;

  typedef enum logic [1:0] {
    SPD_150  = 2'b00,
    SPD_300  = 2'b01,
    SPD_600  = 2'b10,
    SPD_600B = 2'b11
  } speed_e;

  // throttle, request flag, then XOR of the three nibbles of those 12 bits
  function automatic logic [FRAME_W-1:0] pack_frame(input logic [THR_W-1:0] thr,
                                                    input logic req);
    logic [WORD_W-1:0] w;
    w = {thr, req};
    return {w, w[11:8] ^ w[7:4] ^ w[3:0]};
  endfunction
endpackage

// File: rtl/pft_rst_sync.sv
module pft_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/pft_timebase.sv
module pft_timebase
  import pft_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [PRE_W-1:0]  presc_in,
  output logic [TICK_W-1:0] tick_cnt,
  output logic              slot_end,
  output logic              frame_end,
  output logic              running
);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_TICKS - 1);
  localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(FRAME_W - 1);

  logic [PRE_W-1:0]  lim_q, lim_d, pre_q, pre_d;
  logic [TICK_W-1:0] tick_q, tick_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic              run_q, run_d;
  logic              tick_en, reg_en;

  assign tick_en   = run_q && (pre_q == lim_q);
  assign slot_end  = tick_en && (tick_q == TICK_LAST);
  assign frame_end = slot_end && (bit_q == BIT_LAST);
  assign reg_en    = start || abort || run_q;

  always_comb begin
    lim_d  = lim_q;
    pre_d  = pre_q;
    tick_d = tick_q;
    bit_d  = bit_q;
    run_d  = run_q;
    if (start) begin
      lim_d  = presc_in;
      pre_d  = '0;
      tick_d = '0;
      bit_d  = '0;
      run_d  = 1'b1;
    end else if (abort) begin
      pre_d  = '0;
      tick_d = '0;
      bit_d  = '0;
      run_d  = 1'b0;
    end else if (run_q) begin
      pre_d = tick_en ? '0 : pre_q + PRE_W'(1);
      if (tick_en)   tick_d = slot_end ? '0 : tick_q + TICK_W'(1);
      if (slot_end)  bit_d  = frame_end ? '0 : bit_q + BIT_W'(1);
      if (frame_end) run_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      pre_q  <= '0;
      tick_q <= '0;
      bit_q  <= '0;
      run_q  <= 1'b0;
    end else if (reg_en) begin
      lim_q  <= lim_d;
      pre_q  <= pre_d;
      tick_q <= tick_d;
      bit_q  <= bit_d;
      run_q  <= run_d;
    end
  end

  assign tick_cnt = tick_q;
  assign running  = run_q;

  assert_tick_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (tick_q <= TICK_LAST));
  assert_tick_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && (tick_q != TICK_LAST) && !abort && !start) |=> (tick_q == $past(tick_q) + TICK_W'(1)));
  assert_start_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && tick_q == '0 && bit_q == '0 && pre_q == '0));
  assert_frame_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !start) |=> !run_q);
  assert_abort_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !start) |=> !run_q);
endmodule

// File: rtl/pft_channel.sv
module pft_channel
  import pft_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wr_en,
  input  logic [THR_W-1:0]  wr_thr,
  input  logic              wr_req,
  input  logic              start,
  input  logic              slot_end,
  input  logic              frame_end,
  input  logic [TICK_W-1:0] tick_cnt,
  input  logic              invert,
  output logic              staged,
  output logic              busy,
  output logic              line
);
  localparam logic [TICK_W-1:0] ONE_LIM  = TICK_W'(HIGH_ONE);
  localparam logic [TICK_W-1:0] ZERO_LIM = TICK_W'(HIGH_ZERO);

  logic [WORD_W-1:0]  stage_q, stage_d;
  logic               pend_q, pend_d;
  logic [FRAME_W-1:0] shreg_q, shreg_d;
  logic               busy_q, busy_d;
  logic               launch, active;
  logic [TICK_W-1:0]  high_lim;

  assign launch = start && pend_q;

  always_comb begin
    stage_d = stage_q;
    pend_d  = pend_q;
    shreg_d = shreg_q;
    busy_d  = busy_q;
    if (!enable) begin
      busy_d = 1'b0;
    end else begin
      if (launch) begin
        busy_d  = 1'b1;
        shreg_d = pack_frame(stage_q[WORD_W-1:1], stage_q[0]);
        pend_d  = 1'b0;
      end else if (busy_q && slot_end) begin
        shreg_d = {shreg_q[FRAME_W-2:0], 1'b0};
        if (frame_end) busy_d = 1'b0;
      end
      if (wr_en && !busy_q) begin
        stage_d = {wr_thr, wr_req};
        pend_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      pend_q  <= 1'b0;
      shreg_q <= '0;
      busy_q  <= 1'b0;
    end else begin
      stage_q <= stage_d;
      pend_q  <= pend_d;
      shreg_q <= shreg_d;
      busy_q  <= busy_d;
    end
  end

  assign high_lim = shreg_q[FRAME_W-1] ? ONE_LIM : ZERO_LIM;
  assign active   = busy_q && (tick_cnt < high_lim);
  assign line     = active ^ invert;
  assign busy     = busy_q;
  assign staged   = pend_q;

  assert_idle_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (line == invert));
  assert_busy_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && wr_en) |=> $stable(stage_q));
  assert_disable_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy_q);
  assert_rise_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(start));
  assert_fall_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(frame_end || !enable));
endmodule

// File: rtl/pulse_frame_tx.sv
module pulse_frame_tx
  import pft_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CLK_HZ = 48_000_000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic [1:0]              mode,
  input  logic [NUM_CH-1:0]       invert,
  input  logic [NUM_CH-1:0]       wr_en,
  input  logic [NUM_CH*THR_W-1:0] wr_throttle,
  input  logic [NUM_CH-1:0]       wr_telem,
  input  logic                    commit,
  output logic [NUM_CH-1:0]       busy,
  output logic [NUM_CH-1:0]       line_out
);
  localparam int DIV_150 = CLK_HZ / RATE_150_HZ;
  localparam int PRE_W   = (DIV_150 > 1) ? $clog2(DIV_150) : 1;
  localparam logic [PRE_W-1:0] PRE_150 = PRE_W'(CLK_HZ / RATE_150_HZ - 1);
  localparam logic [PRE_W-1:0] PRE_300 = PRE_W'(CLK_HZ / RATE_300_HZ - 1);
  localparam logic [PRE_W-1:0] PRE_600 = PRE_W'(CLK_HZ / RATE_600_HZ - 1);

  logic              srst_n;
  logic [PRE_W-1:0]  presc_sel;
  logic [TICK_W-1:0] tick_cnt;
  logic              slot_end, frame_end, running, start;
  logic [NUM_CH-1:0] staged_w, busy_w;

  pft_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .srst_n(srst_n)
  );

  always_comb begin
    case (speed_e'(mode))
      SPD_150: presc_sel = PRE_150;
      SPD_300: presc_sel = PRE_300;
      default: presc_sel = PRE_600;
    endcase
  end

  assign start = enable && commit && !running && (|staged_w);

  pft_timebase #(.PRE_W(PRE_W)) u_tb (
    .clk(clk), .rst_n(srst_n), .start(start), .abort(!enable),
    .presc_in(presc_sel), .tick_cnt(tick_cnt), .slot_end(slot_end),
    .frame_end(frame_end), .running(running)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pft_channel u_ch (
      .clk(clk), .rst_n(srst_n), .enable(enable), .wr_en(wr_en[c]),
      .wr_thr(wr_throttle[c*THR_W +: THR_W]), .wr_req(wr_telem[c]),
      .start(start), .slot_end(slot_end), .frame_end(frame_end),
      .tick_cnt(tick_cnt), .invert(invert[c]), .staged(staged_w[c]),
      .busy(busy_w[c]), .line(line_out[c])
    );
  end

  assign busy = busy_w;

  assert_busy_in_run_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (|busy_w) |-> running);
  assert_run_has_busy_R8: assert property (@(posedge clk) disable iff (!srst_n)
    running |-> (|busy_w));
  assert_commit_in_flight_R11: assert property (@(posedge clk) disable iff (!srst_n)
    (running && commit && !frame_end) |=> $stable(busy_w));
endmodule

// File: tb/test_pulse_frame_tx.sv
`timescale 1ns/1ps
module test_pulse_frame_tx;
  localparam int NCH = 4;
  localparam int CLK = 48_000_000;

  logic clk = 1'b0;
  logic rst_n, enable, commit;
  logic [1:0] mode;
  logic [NCH-1:0] invert, wr_en, wr_telem, busy, line_out;
  logic [NCH*11-1:0] wr_throttle;

  int errors = 0;
  int checks = 0;
  logic [10:0] thr_v [NCH];
  logic        req_v [NCH];

  always #2.5 clk = ~clk;

  pulse_frame_tx #(.NUM_CH(NCH), .CLK_HZ(CLK)) i_pulse_frame_tx (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode), .invert(invert),
    .wr_en(wr_en), .wr_throttle(wr_throttle), .wr_telem(wr_telem),
    .commit(commit), .busy(busy), .line_out(line_out)
  );

  function automatic logic [15:0] ref_frame(input logic [10:0] t, input logic r);
    logic [11:0] x;
    x = {t, r};
    return {x, x[11:8] ^ x[7:4] ^ x[3:0]};
  endfunction

  function automatic int clocks_per_tick(input logic [1:0] md);
    case (md)
      2'b00:   return CLK / 3_000_000;
      2'b01:   return CLK / 6_000_000;
      default: return CLK / 12_000_000;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic stage(input int ch, input logic [10:0] t, input logic r);
    wr_en[ch] = 1'b1;
    wr_throttle[ch*11 +: 11] = t;
    wr_telem[ch] = r;
    thr_v[ch] = t;
    req_v[ch] = r;
    @(negedge clk);
    wr_en = '0;
  endtask

  // kind: 0 none, 1 mode change, 3 write to busy ch0, 4 write idle ch3 plus commit
  task automatic run_frame(input logic [1:0] md, input logic [NCH-1:0] mask,
                           input int mid_k, input int kind, input string tag);
    int p, n;
    int bad [NCH];
    int first [NCH];
    int busy_bad;
    mode = md;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    p = clocks_per_tick(md);
    n = 320 * p;
    busy_bad = 0;
    for (int c = 0; c < NCH; c++) begin bad[c] = 0; first[c] = -1; end
    for (int k = 0; k < n; k++) begin
      for (int c = 0; c < NCH; c++) begin
        logic [15:0] f;
        logic act, exp_l;
        int b, t;
        f = ref_frame(thr_v[c], req_v[c]);
        b = k / (20 * p);
        t = (k / p) % 20;
        act = mask[c] && (t < (f[15-b] ? 14 : 7));
        exp_l = act ^ invert[c];
        if (line_out[c] !== exp_l) begin
          if (bad[c] == 0) first[c] = k;
          bad[c]++;
        end
      end
      if (busy !== mask) busy_bad++;
      if (k == mid_k) begin
        if (kind == 1) mode = ~md;
        if (kind == 3) begin wr_en[0] = 1'b1; wr_throttle[10:0] = 11'h123; end
        if (kind == 4) begin
          wr_en[3] = 1'b1; wr_throttle[43:33] = 11'h4B6; wr_telem[3] = 1'b1;
          commit = 1'b1;
        end
      end
      if (k == mid_k + 1) begin wr_en = '0; commit = 1'b0; end
      @(negedge clk);
    end
    for (int c = 0; c < NCH; c++)
      check(bad[c] == 0, tag, $sformatf("ch%0d waveform mismatches, first at cycle %0d", c, first[c]),
            bad[c], 0);
    check(busy_bad == 0, "R7 R8", {tag, " busy tracked frame"}, busy_bad, 0);
    check(busy == '0, "R8", {tag, " busy clear after 320 ticks"}, busy, 0);
    check(line_out == invert, "R8 R10", {tag, " line idle after frame"}, line_out, invert);
    mode = md;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b1; commit = 1'b0; mode = 2'b10;
    invert = '0; wr_en = '0; wr_throttle = '0; wr_telem = '0;
    for (int c = 0; c < NCH; c++) begin thr_v[c] = '0; req_v[c] = 1'b0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(busy == '0, "R12", "busy after reset", busy, 0);
    check(line_out == '0, "R12", "lines idle after reset", line_out, 0);
    invert = 4'b1010;
    @(negedge clk);
    check(line_out == 4'b1010, "R10", "idle level follows invert", line_out, 4'b1010);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    @(negedge clk);
    check(busy == '0, "R7", "commit with nothing staged", busy, 0);

    // R1 R2 R3 R4 R5 sweep over throttle and flag patterns at the fastest rate
    for (int i = 0; i < 10; i++) begin
      invert = 4'(i * 5);
      for (int c = 0; c < NCH; c++) begin
        logic [10:0] v;
        if (i == 0)      v = 11'h000;
        else if (i == 1) v = 11'h7FF;
        else if (i == 2) v = 11'h555 ^ 11'(c);
        else             v = 11'((i * 157 + c * 613) ^ (1 << (i + c)));
        stage(c, v, 1'((i + c) & 1));
      end
      run_frame(2'b10, 4'b1111, -5, 0, "R1 R2 R3 R4 R5");
    end

    // R6 slower rates, alternate code, and mode change in flight
    stage(1, 11'h3A5, 1'b1); stage(2, 11'h0F0, 1'b0);
    run_frame(2'b01, 4'b0110, 700, 1, "R6 rate300 mode-change");
    stage(0, 11'h6C3, 1'b0); stage(3, 11'h1E1, 1'b1);
    run_frame(2'b00, 4'b1001, -5, 0, "R6 rate150");
    stage(0, 11'h2D2, 1'b1);
    run_frame(2'b11, 4'b0001, -5, 0, "R6 code11");

    // R11 last write wins, then a write to a busy channel is dropped
    invert = 4'b0000;
    stage(0, 11'h111, 1'b0); stage(0, 11'h70E, 1'b1);
    run_frame(2'b10, 4'b0001, 200, 3, "R11 busy write");
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    @(negedge clk);
    check(busy == '0, "R11", "write during busy not staged", busy, 0);

    // R11 commit in flight ignored; idle channel write taken and sent later
    stage(1, 11'h0AB, 1'b0);
    run_frame(2'b10, 4'b0010, 300, 4, "R11 commit in flight");
    thr_v[3] = 11'h4B6; req_v[3] = 1'b1;
    run_frame(2'b10, 4'b1000, -5, 0, "R11 deferred send");

    // R9 disabled writes and commits are ignored
    enable = 1'b0;
    stage(1, 11'h321, 1'b1);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    repeat (3) @(negedge clk);
    check(busy == '0, "R9", "commit ignored while disabled", busy, 0);
    check(line_out == invert, "R9", "lines idle while disabled", line_out, invert);
    enable = 1'b1;
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    @(negedge clk);
    check(busy == '0, "R9", "disabled write left nothing staged", busy, 0);

    // R9 dropping enable aborts a frame
    invert = 4'b0100;
    stage(2, 11'h7FF, 1'b1);
    commit = 1'b1;
    @(negedge clk);
    commit = 1'b0;
    @(negedge clk);
    check(busy == 4'b0100, "R7", "abort frame started", busy, 4'b0100);
    check(line_out == 4'b0000, "R10", "inverted channel active low", line_out, 4'b0000);
    repeat (40) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(busy == '0, "R9", "abort clears busy", busy, 0);
    repeat (30) @(negedge clk);
    check(line_out == invert, "R9", "no pulses after abort", line_out, invert);
    enable = 1'b1;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule